// File: doc/BRIEF.md
# Collision and SQE Test Controller

This block decides when the attachment-side collision pair must carry a gated 10 MHz square wave. Three things turn the oscillator on. The first is a collision: transmit and fiber receive both active while loopback is in force. The second is an active jabber request. The third is the signal-quality-error test burst. That burst is a short pulse of collision signalling placed in the inter-packet gap after every transmission. It tells the station that the collision path works.

The block also chooses the data source for the receive pair: looped-back transmit data or the fiber receive data. It drives an active-low collision LED through a retriggerable pulse stretcher. All timing is counted in clock cycles and set by parameters. The defaults suit a 200 MHz clock.

Top module: `col_sqe_ctrl`

## Requirements
- R1: While loopback is enabled (`loop_off`=0), `tx_active` and `rx_active` both high at a clock edge make `col_en` high from that edge on.
- R2: With `loop_off`=1, simultaneous transmit and receive never count as a collision. `col_en` stays low unless jabber or an SQE burst raises it.
- R3: A collision holds `col_en` high until either `tx_active` or `rx_active` goes low. `col_en` then drops one clock later.
- R4: While `col_en` is high, `col_osc` is a square wave with a period of 2*`OSC_HALF` cycles (20 cycles = 10 MHz at 200 MHz). Its high and low phases are equal.
- R5: `jabber_req` high makes `col_en` high one clock later, with no transmit or receive activity needed.
- R6: When `tx_active` falls and the test is allowed, `col_en` rises `SQE_DLY`+1 cycles after the fall is presented and stays high for exactly `SQE_LEN` cycles.
- R7: No SQE burst follows a transmission that ends while `sqe_en`=0, while `low_light`=1, or while `jabber_req`=1.
- R8: If `tx_active` returns high while an SQE burst is still pending, that burst is cancelled.
- R9: `rx_sel_fiber` is 1 (fiber data) whenever reception was active at the previous edge. It is 0 (looped transmit data) otherwise.
- R10: `col_led_n` goes low while a collision is present. It stays low for `LED_LEN` cycles after the collision clears, and each new collision restarts that hold.
- R11: `col_osc` is low whenever `col_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_active | input | 1 | Attachment transmit pair is carrying data |
| rx_active | input | 1 | Fiber receive path is unsquelched |
| jabber_req | input | 1 | Jabber state is active |
| low_light | input | 1 | Fiber link reports low light |
| loop_off | input | 1 | Strap: 1 disables loopback and collision detection |
| sqe_en | input | 1 | 1 enables the SQE test burst |
| col_en | output | 1 | Collision pair should be driven |
| col_osc | output | 1 | Gated 10 MHz collision square wave |
| rx_sel_fiber | output | 1 | Receive pair source: 1 fiber, 0 looped transmit |
| col_led_n | output | 1 | Stretched collision LED, active low |

## Verification
The hardest state to reach is a cancelled SQE burst. The stimulus ends a transmission with the test enabled, waits about half the gap delay, and restarts transmit. Transmit is held past the point where the burst would have fired, and the bench confirms the collision pair stays quiet. Only then is transmit released again, to show that the next gap still produces a full burst. Jabber suppression needs a similar setup. The jabber request must be high on the exact cycle transmit falls, then drop one cycle later. Otherwise the jabber itself would hide whether a burst happened.

// File: rtl/col_sqe_pkg.sv
package col_sqe_pkg;
    typedef enum logic [1:0] {
        SQE_IDLE  = 2'd0,
        SQE_WAIT  = 2'd1,
        SQE_BURST = 2'd2
    } sqe_state_e;
endpackage

// File: rtl/col_sqe_timer.sv
module col_sqe_timer
    import col_sqe_pkg::*;
#(
    parameter int SQE_DLY = 200,
    parameter int SQE_LEN = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_active,
    input  logic allow,
    output logic burst
);
    localparam int MAXC = (SQE_DLY > SQE_LEN) ? SQE_DLY : SQE_LEN;
    localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;

    typedef struct packed {
        sqe_state_e    st;
        logic [CW-1:0] cnt;
        logic          tx;
    } tmr_t;

    tmr_t cur_q, nxt_d;

    always_comb begin
        nxt_d    = cur_q;
        nxt_d.tx = tx_active;
        unique case (cur_q.st)
            SQE_IDLE: begin
                // falling edge of transmit arms the gap delay
                if (cur_q.tx && !tx_active && allow) begin
                    nxt_d.st  = SQE_WAIT;
                    nxt_d.cnt = CW'(SQE_DLY - 1);
                end
            end
            SQE_WAIT: begin
                if (tx_active) begin
                    nxt_d.st = SQE_IDLE;
                end else if (cur_q.cnt == '0) begin
                    nxt_d.st  = SQE_BURST;
                    nxt_d.cnt = CW'(SQE_LEN - 1);
                end else begin
                    nxt_d.cnt = cur_q.cnt - 1'b1;
                end
            end
            SQE_BURST: begin
                if (cur_q.cnt == '0) nxt_d.st = SQE_IDLE;
                else                 nxt_d.cnt = cur_q.cnt - 1'b1;
            end
            default: nxt_d.st = SQE_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{st: SQE_IDLE, cnt: '0, tx: 1'b0};
        else        cur_q <= nxt_d;
    end

    assign burst = (cur_q.st == SQE_BURST);
endmodule

// File: rtl/col_osc_gen.sv
module col_osc_gen #(
    parameter int OSC_HALF = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic osc
);
    localparam int HW = (OSC_HALF > 1) ? $clog2(OSC_HALF) : 1;

    typedef struct packed {
        logic [HW-1:0] ph;
        logic          lvl;
    } osc_t;

    osc_t osc_q, osc_d;

    always_comb begin
        osc_d = osc_q;
        if (!en) begin
            osc_d.ph  = '0;
            osc_d.lvl = 1'b0;
        end else if (osc_q.ph == HW'(OSC_HALF - 1)) begin
            osc_d.ph  = '0;
            osc_d.lvl = ~osc_q.lvl;
        end else begin
            osc_d.ph = osc_q.ph + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) osc_q <= '0;
        else        osc_q <= osc_d;
    end

    assign osc = osc_q.lvl & en;
endmodule

// File: rtl/col_led_stretch.sv
module col_led_stretch #(
    parameter int LED_LEN = 3_200_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic led_n
);
    localparam int LW = $clog2(LED_LEN + 1);

    logic [LW-1:0] hold_q, hold_d;

    always_comb begin
        if (trig)                hold_d = LW'(LED_LEN);
        else if (hold_q != '0)   hold_d = hold_q - 1'b1;
        else                     hold_d = hold_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign led_n = (hold_q == '0);
endmodule

// File: rtl/col_sqe_ctrl.sv
module col_sqe_ctrl #(
    parameter int OSC_HALF = 10,
    parameter int SQE_DLY  = 200,
    parameter int SQE_LEN  = 200,
    parameter int LED_LEN  = 3_200_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_active,
    input  logic rx_active,
    input  logic jabber_req,
    input  logic low_light,
    input  logic loop_off,
    input  logic sqe_en,
    output logic col_en,
    output logic col_osc,
    output logic rx_sel_fiber,
    output logic col_led_n
);
    typedef struct packed {
        logic col;
        logic jab;
        logic rxs;
    } top_t;

    top_t top_q, top_d;
    logic col_q;
    logic burst;
    logic sqe_allow;

    always_comb begin
        top_d     = top_q;
        top_d.col = !loop_off && tx_active && rx_active;
        top_d.jab = jabber_req;
        top_d.rxs = rx_active;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign col_q     = top_q.col;
    assign sqe_allow = sqe_en && !low_light && !jabber_req;

    col_sqe_timer #(.SQE_DLY(SQE_DLY), .SQE_LEN(SQE_LEN)) u_tmr (
        .clk(clk), .rst_n(rst_n), .tx_active(tx_active),
        .allow(sqe_allow), .burst(burst)
    );

    assign col_en       = col_q | top_q.jab | burst;
    assign rx_sel_fiber = top_q.rxs;

    col_osc_gen #(.OSC_HALF(OSC_HALF)) u_osc (
        .clk(clk), .rst_n(rst_n), .en(col_en), .osc(col_osc)
    );

    col_led_stretch #(.LED_LEN(LED_LEN)) u_led (
        .clk(clk), .rst_n(rst_n), .trig(col_q), .led_n(col_led_n)
    );
endmodule

// File: rtl/col_sqe_chk.sv
module col_sqe_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_active,
    input logic rx_active,
    input logic jabber_req,
    input logic loop_off,
    input logic col_en,
    input logic col_osc,
    input logic col_led_n,
    input logic col_q,
    input logic burst
);
    assert_collide_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!loop_off && tx_active && rx_active) |=> col_en);

    assert_loop_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        loop_off |=> !col_q);

    assert_jabber_R5: assert property (@(posedge clk) disable iff (!rst_n)
        jabber_req |=> col_en);

    assert_cancel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_active |=> !$rose(burst));

    assert_led_on_R10: assert property (@(posedge clk) disable iff (!rst_n)
        col_q |=> !col_led_n);

    assert_osc_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !col_en |-> !col_osc);
endmodule

bind col_sqe_ctrl col_sqe_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tx_active(tx_active), .rx_active(rx_active),
    .jabber_req(jabber_req), .loop_off(loop_off), .col_en(col_en),
    .col_osc(col_osc), .col_led_n(col_led_n), .col_q(col_q), .burst(burst)
);

// File: tb/tb_col_sqe_ctrl.sv
`timescale 1ns/1ps
module tb_col_sqe_ctrl;
    localparam int HALF = 10;
    localparam int DLY  = 200;
    localparam int LEN  = 200;
    localparam int LEDL = 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_active = 0, rx_active = 0, jabber_req = 0, low_light = 0;
    logic loop_off = 0, sqe_en = 0;
    logic col_en, col_osc, rx_sel_fiber, col_led_n;

    always #2.5 clk = ~clk;

    col_sqe_ctrl #(.OSC_HALF(HALF), .SQE_DLY(DLY), .SQE_LEN(LEN), .LED_LEN(LEDL)) dut (
        .clk(clk), .rst_n(rst_n), .tx_active(tx_active), .rx_active(rx_active),
        .jabber_req(jabber_req), .low_light(low_light), .loop_off(loop_off),
        .sqe_en(sqe_en), .col_en(col_en), .col_osc(col_osc),
        .rx_sel_fiber(rx_sel_fiber), .col_led_n(col_led_n)
    );

    typedef struct {
        int req;
        int sig;
        int exp;
        int dly;
    } item_t;

    item_t sb_q[$];
    bit    busy = 0;
    bit    done = 0;
    int    checks = 0;
    int    failures = 0;

    function automatic int pick(int sig);
        case (sig)
            0: return int'(col_en);
            1: return int'(col_osc);
            2: return int'(rx_sel_fiber);
            default: return int'(col_led_n);
        endcase
    endfunction

    task automatic chk_int(int req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL R%0d %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // monitor: pops expected items and compares at the stated negedge
    initial begin
        forever begin
            item_t it;
            wait (sb_q.size() > 0);
            it = sb_q.pop_front();
            busy = 1;
            repeat (it.dly) @(negedge clk);
            chk_int(it.req, $sformatf("sig%0d", it.sig), pick(it.sig), it.exp);
            busy = 0;
        end
    end

    task automatic expect_at(int req, int sig, int exp, int dly);
        sb_q.push_back('{req, sig, exp, dly});
    endtask

    task automatic drain();
        wait (sb_q.size() == 0 && !busy);
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure_osc();   // R4
        int hi = 0, lo = 0, guard = 0;
        while (col_osc !== 1'b0 && guard < 100) begin @(negedge clk); guard++; end
        while (col_osc !== 1'b1 && guard < 100) begin @(negedge clk); guard++; end
        while (col_osc === 1'b1 && guard < 200) begin @(negedge clk); hi++; guard++; end
        while (col_osc === 1'b0 && guard < 300) begin @(negedge clk); lo++; guard++; end
        chk_int(4, "osc high cycles", hi, HALF);
        chk_int(4, "osc low cycles", lo, HALF);
    endtask

    task automatic measure_sqe(int req);   // call right after tx falls
        int d = 0, w = 0;
        while (col_en !== 1'b1 && d < 1000) begin @(negedge clk); d++; end
        while (col_en === 1'b1 && w < 1000) begin @(negedge clk); w++; end
        chk_int(req, "sqe delay", d, DLY + 1);
        chk_int(req, "sqe width", w, LEN);
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        // reset state
        expect_at(10, 3, 1, 1);
        expect_at(11, 1, 0, 0);
        expect_at(1, 0, 0, 0);
        expect_at(9, 2, 0, 0);
        drain();

        // transmit only: looped data, no collision (R9)
        tx_active = 1;
        expect_at(9, 2, 0, 1);
        expect_at(1, 0, 0, 0);
        drain();

        // collision (R1, R9) and oscillator (R4)
        rx_active = 1;
        expect_at(1, 0, 1, 1);
        expect_at(9, 2, 1, 0);
        drain();
        measure_osc();

        // receive drops: collision clears (R3, R9)
        rx_active = 0;
        expect_at(3, 0, 0, 1);
        expect_at(9, 2, 0, 0);
        drain();

        // collision again, then transmit drops (R3), receive only (R9)
        rx_active = 1;
        expect_at(1, 0, 1, 1);
        drain();
        tx_active = 0;
        expect_at(3, 0, 0, 1);
        expect_at(9, 2, 1, 0);
        expect_at(11, 1, 0, 0);
        drain();
        rx_active = 0;
        tick(2);

        // loopback disabled: no collision (R2)
        loop_off = 1; tx_active = 1; rx_active = 1;
        expect_at(2, 0, 0, 1);
        expect_at(2, 0, 0, 5);
        drain();
        tx_active = 0; rx_active = 0;
        tick(2);
        loop_off = 0;

        // jabber (R5)
        jabber_req = 1;
        expect_at(5, 0, 1, 1);
        drain();
        jabber_req = 0;
        expect_at(5, 0, 0, 1);
        drain();

        // SQE burst timing (R6)
        sqe_en = 1;
        tx_active = 1; tick(5);
        tx_active = 0;
        measure_sqe(6);
        tick(5);

        // suppression by mode (R7)
        sqe_en = 0;
        tx_active = 1; tick(5);
        tx_active = 0;
        expect_at(7, 0, 0, DLY + 1 + LEN / 2);
        drain();
        tick(LEN);

        // suppression by low light (R7)
        sqe_en = 1; low_light = 1;
        tx_active = 1; tick(5);
        tx_active = 0;
        tick(1);
        low_light = 0;
        expect_at(7, 0, 0, DLY + LEN / 2);
        drain();
        tick(LEN);

        // suppression by jabber present at end of transmit (R7)
        tx_active = 1; tick(5);
        tx_active = 0; jabber_req = 1;
        tick(1);
        jabber_req = 0;
        expect_at(7, 0, 0, DLY + LEN / 2);
        drain();
        tick(LEN);

        // pending burst cancelled by new transmission (R8)
        tx_active = 1; tick(5);
        tx_active = 0;
        tick(DLY / 2);
        tx_active = 1;
        expect_at(8, 0, 0, DLY / 2 + 1 + LEN / 2);
        drain();
        tx_active = 0;
        measure_sqe(8);
        sqe_en = 0;

        // LED stretch and retrigger (R10)
        tick(LEDL + 10);
        expect_at(10, 3, 1, 0);
        drain();
        tx_active = 1; rx_active = 1;
        expect_at(10, 3, 0, 3);
        drain();
        rx_active = 0;
        expect_at(10, 3, 0, LEDL);
        expect_at(10, 3, 1, 1);
        drain();
        rx_active = 1; tick(3);
        rx_active = 0;
        tick(LEDL / 2);
        rx_active = 1; tick(3);
        rx_active = 0;
        expect_at(10, 3, 0, LEDL);
        expect_at(10, 3, 1, 1);
        drain();
        tx_active = 0;
        tick(3);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(150000 * 5);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule